// File: doc/BRIEF.md
# Synthesizer Powerup and Self-Tune Sequencer

This block decides whether a frequency synthesizer is powered and, each time the loop is started, steps it through a timed startup. The synthesizer is on only when a hardware enable pin is high and a software power bit is set. A low pin turns the synthesizer off whatever the software bit holds. While the pin is high, the software bit alone controls power. The reference path enable and the RF path enable always switch together.

A startup sequence begins when the synthesizer comes on, when software writes 1 to the power bit, or when a new divider value is written while the synthesizer is on. Each sequence has three phases. A self-tune phase lasts 6.5 phase-detector update periods. A lock phase follows, and the synthesizer counts as settled 28 update periods after the start. All timing runs on a strobe that pulses once per half update period, so the fractional self-tune length is an exact count of 13 half periods.

A lock-warning flag for an auxiliary output is high while self-tune runs and low during the lock phase. Once the output has settled, the flag latches high if the loop reports that it is near the edge of its correction range. That tells software to re-tune the loop.

Top module: `synth_pwr_seq`

## Requirements
- R1: While reset is held, and on the first cycle after reset, ref_en, rf_en, tuning, settled and lock_bar are all 0.
- R2: After each clock edge, ref_en and rf_en both equal pwr_pin AND the software power bit. The power bit takes pd_val on an edge where pd_wr is 1 and otherwise keeps its value. It resets to 0.
- R3: On the edge after pwr_pin is sampled low, or after a write of 0 to the power bit, both enables are 0. The sequence is abandoned, so tuning, settled and lock_bar are 0.
- R4: A start happens on an edge where the synthesizer is on afterwards and one of these holds: it was off before that edge, or pd_wr=1 with pd_val=1. After a start, tuning=1, settled=0 and the half-period count is 0. A half_tick in the start cycle is not counted.
- R5: An n_wr pulse while the synthesizer is on after the edge restarts the sequence as in R4. An n_wr pulse while it is off has no effect on any output.
- R6: tuning stays 1 until the 13th counted half_tick after the start (TUNE_HALVES). On that edge the block enters the lock phase, where tuning=0 and settled=0.
- R7: settled becomes 1 on the edge of the 56th counted half_tick after the start (SETTLE_HALVES). It stays 1 until the next start or power-off.
- R8: lock_bar is 1 whenever tuning is 1, and 0 during the lock phase.
- R9: While settled is 1, range_lim=1 at an edge sets lock_bar on that edge. lock_bar then stays 1 until the next start or power-off. range_lim has no effect outside the settled state.
- R10: A start during a running or settled sequence clears the half-period count and re-enters self-tune. The full 13 and 56 half_tick windows are then measured again from that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_tick | input | 1 | One-cycle strobe, once per half update period |
| pwr_pin | input | 1 | Hardware enable pin; low forces the synthesizer off |
| pd_wr | input | 1 | Write strobe for the software power bit |
| pd_val | input | 1 | Value written to the software power bit (1 = on) |
| n_wr | input | 1 | Strobe marking a write of a new divider value |
| range_lim | input | 1 | Loop reports it is near its correction limit |
| ref_en | output | 1 | Reference path enable |
| rf_en | output | 1 | RF path enable |
| tuning | output | 1 | Self-tune phase active |
| settled | output | 1 | Output frequency settled |
| lock_bar | output | 1 | Lock warning flag for the auxiliary output |

## Verification
The hardest case to reach is a settled sequence that carries a latched range warning and is then hit by a restart. The settled state needs 56 counted half ticks with no power drop and no divider write on the way. Random stimulus with frequent writes seldom gets that far. The bench therefore runs directed phases that hold the pin high and tick every cycle to reach the settled state. It then raises range_lim, checks that the warning is sticky, and restarts with a divider write. A long random phase runs after that, with writes made sparse so that sequences regularly complete, and its outputs are compared every cycle against a model built from the requirements.

// File: rtl/synth_pwr_seq_pkg.sv
package synth_pwr_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_OFF     = 2'd0,
        SEQ_TUNE    = 2'd1,
        SEQ_LOCK    = 2'd2,
        SEQ_SETTLED = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic sw_on;
        logic pwr_on;
    } gate_regs_t;

    typedef struct packed {
        seq_state_e state;
        logic       lim_seen;
    } fsm_regs_t;

endpackage

// File: rtl/synth_pwr_gate.sv
module synth_pwr_gate
    import synth_pwr_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_pin,
    input  logic pd_wr,
    input  logic pd_val,
    input  logic n_wr,
    output logic on_next,
    output logic on_now,
    output logic start
);

    gate_regs_t r_q, r_d;

    always_comb begin
        r_d       = r_q;
        r_d.sw_on = pd_wr ? pd_val : r_q.sw_on;
        // the pin has priority over the software bit
        r_d.pwr_on = pwr_pin & r_d.sw_on;
        on_next    = r_d.pwr_on;
        start      = r_d.pwr_on & (~r_q.pwr_on | (pd_wr & pd_val) | n_wr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign on_now = r_q.pwr_on;

endmodule

// File: rtl/synth_half_cnt.sv
module synth_half_cnt #(
    parameter int TUNE_HALVES   = 13,
    parameter int SETTLE_HALVES = 56,
    parameter int CW            = $clog2(SETTLE_HALVES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic half_tick,
    output logic hit_tune,
    output logic hit_settle
);

    localparam logic [CW-1:0] TUNE_LAST   = CW'(TUNE_HALVES);
    localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_HALVES);

    logic [CW-1:0] cnt_q, cnt_d, cnt_inc;
    logic          step;

    always_comb begin
        step       = run & half_tick & (cnt_q != SETTLE_LAST);
        cnt_inc    = cnt_q + 1'b1;
        hit_tune   = step & (cnt_inc == TUNE_LAST);
        hit_settle = step & (cnt_inc == SETTLE_LAST);
        if (clear) begin
            cnt_d = '0;
        end else if (step) begin
            cnt_d = cnt_inc;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/synth_seq_fsm.sv
module synth_seq_fsm
    import synth_pwr_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic on_next,
    input  logic start,
    input  logic hit_tune,
    input  logic hit_settle,
    input  logic range_lim,
    output logic run,
    output logic tuning,
    output logic settled,
    output logic lock_bar
);

    fsm_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (!on_next) begin
            r_d.state    = SEQ_OFF;
            r_d.lim_seen = 1'b0;
        end else if (start) begin
            r_d.state    = SEQ_TUNE;
            r_d.lim_seen = 1'b0;
        end else begin
            unique case (r_q.state)
                SEQ_TUNE:    if (hit_tune)   r_d.state = SEQ_LOCK;
                SEQ_LOCK:    if (hit_settle) r_d.state = SEQ_SETTLED;
                SEQ_SETTLED: if (range_lim)  r_d.lim_seen = 1'b1;
                default:     r_d.state = r_q.state;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: SEQ_OFF, lim_seen: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign run      = (r_q.state == SEQ_TUNE) | (r_q.state == SEQ_LOCK);
    assign tuning   = (r_q.state == SEQ_TUNE);
    assign settled  = (r_q.state == SEQ_SETTLED);
    assign lock_bar = tuning | r_q.lim_seen;

endmodule

// File: rtl/synth_pwr_seq.sv
module synth_pwr_seq #(
    parameter int TUNE_HALVES   = 13,
    parameter int SETTLE_HALVES = 56
) (
    input  logic clk,
    input  logic rst_n,
    input  logic half_tick,
    input  logic pwr_pin,
    input  logic pd_wr,
    input  logic pd_val,
    input  logic n_wr,
    input  logic range_lim,
    output logic ref_en,
    output logic rf_en,
    output logic tuning,
    output logic settled,
    output logic lock_bar
);

    localparam int CW = $clog2(SETTLE_HALVES + 1);

    logic on_next, on_now, start;
    logic run, hit_tune, hit_settle;

    synth_pwr_gate gate_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwr_pin (pwr_pin),
        .pd_wr   (pd_wr),
        .pd_val  (pd_val),
        .n_wr    (n_wr),
        .on_next (on_next),
        .on_now  (on_now),
        .start   (start)
    );

    synth_half_cnt #(
        .TUNE_HALVES   (TUNE_HALVES),
        .SETTLE_HALVES (SETTLE_HALVES),
        .CW            (CW)
    ) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (start | ~on_next),
        .run        (run),
        .half_tick  (half_tick),
        .hit_tune   (hit_tune),
        .hit_settle (hit_settle)
    );

    synth_seq_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .on_next    (on_next),
        .start      (start),
        .hit_tune   (hit_tune),
        .hit_settle (hit_settle),
        .range_lim  (range_lim),
        .run        (run),
        .tuning     (tuning),
        .settled    (settled),
        .lock_bar   (lock_bar)
    );

    assign ref_en = on_now;
    assign rf_en  = on_now;

endmodule

// File: rtl/synth_pwr_seq_chk.sv
module synth_pwr_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_pin,
    input logic pd_wr,
    input logic n_wr,
    input logic range_lim,
    input logic rf_en,
    input logic ref_en,
    input logic tuning,
    input logic settled,
    input logic lock_bar
);

    a_r3_pin_low_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_pin |=> (!ref_en && !rf_en && !tuning && !settled));

    a_r8_tune_warns: assert property (@(posedge clk) disable iff (!rst_n)
        tuning |-> lock_bar);

    a_r7_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(tuning && settled));

    a_r4_powerup_tunes: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rf_en) |-> tuning);

    a_r5_nwr_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_en && pwr_pin && n_wr && !pd_wr) |=> tuning);

    a_r9_warn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && lock_bar && pwr_pin && !pd_wr && !n_wr) |=> (settled && lock_bar));

    a_r9_warn_set: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && range_lim && pwr_pin && !pd_wr && !n_wr) |=> lock_bar);

endmodule

bind synth_pwr_seq synth_pwr_seq_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_pin   (pwr_pin),
    .pd_wr     (pd_wr),
    .n_wr      (n_wr),
    .range_lim (range_lim),
    .rf_en     (rf_en),
    .ref_en    (ref_en),
    .tuning    (tuning),
    .settled   (settled),
    .lock_bar  (lock_bar)
);

// File: tb/synth_pwr_seq_tb.sv
`timescale 1ns/1ps
module synth_pwr_seq_tb_top;

    localparam int TH = 13;
    localparam int SH = 56;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic half_tick = 1'b0, pwr_pin = 1'b0, pd_wr = 1'b0, pd_val = 1'b0;
    logic n_wr = 1'b0, range_lim = 1'b0;
    logic ref_en, rf_en, tuning, settled, lock_bar;

    int n_chk = 0;
    int n_bad = 0;

    // bench model state, built from the requirements
    logic m_sw = 1'b0, m_on = 1'b0, m_lim = 1'b0;
    int   m_ph = 0;   // 0 off, 1 tune, 2 lock, 3 settled
    int   m_cnt = 0;

    always #2 clk = ~clk;

    synth_pwr_seq dut_i (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .pwr_pin(pwr_pin),
        .pd_wr(pd_wr), .pd_val(pd_val), .n_wr(n_wr), .range_lim(range_lim),
        .ref_en(ref_en), .rf_en(rf_en), .tuning(tuning), .settled(settled),
        .lock_bar(lock_bar)
    );

    function automatic logic [4:0] exp_vec();
        logic t, s;
        t = (m_ph == 1);
        s = (m_ph == 3);
        return {m_on, m_on, t, s, t | m_lim};
    endfunction

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step();
        logic sw_d, on_d, st;
        sw_d = pd_wr ? pd_val : m_sw;
        on_d = pwr_pin & sw_d;
        st   = on_d & (~m_on | (pd_wr & pd_val) | n_wr);
        if (!on_d) begin
            m_ph = 0; m_cnt = 0; m_lim = 1'b0;
        end else if (st) begin
            m_ph = 1; m_cnt = 0; m_lim = 1'b0;
        end else if (m_ph == 1 || m_ph == 2) begin
            if (half_tick) begin
                m_cnt++;
                if (m_ph == 1 && m_cnt == TH) m_ph = 2;
                if (m_ph == 2 && m_cnt == SH) m_ph = 3;
            end
        end else if (m_ph == 3 && range_lim) begin
            m_lim = 1'b1;
        end
        m_sw = sw_d;
        m_on = on_d;
    endtask

    // one clock: inputs already set; sample 1 ns after the edge
    task automatic cyc(input string req);
        @(posedge clk);
        model_step();
        #1;
        chk(req, {ref_en, rf_en, tuning, settled, lock_bar}, exp_vec());
    endtask

    task automatic idle_in();
        pd_wr = 0; pd_val = 0; n_wr = 0; range_lim = 0; half_tick = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int tcount;
        int scount;
        void'($urandom(32'h5eed_1234));
        // R1: reset state
        #1;
        chk("R1", {ref_en, rf_en, tuning, settled, lock_bar}, 5'b0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cyc("R1");

        // R5: divider write while off is ignored
        pwr_pin = 1; n_wr = 1;
        cyc("R5");
        idle_in();
        cyc("R5");
        chk("R5", {ref_en, tuning}, 2'b00);

        // R4/R6/R7/R8: power up by software write, tick every cycle
        pd_wr = 1; pd_val = 1; half_tick = 1;
        cyc("R4");
        chk("R4", {rf_en, tuning, lock_bar}, 3'b111);
        pd_wr = 0; pd_val = 0;
        tcount = 1; scount = 0;
        for (int i = 0; i < SH + 4; i++) begin
            cyc("R6");
            if (tuning) tcount++;
            if (!settled) scount++;
            if (!tuning && !settled) chk("R8", {1'b0, lock_bar}, 2'b00);
        end
        chk("R6", 5'(tcount), 5'(TH));
        chk("R7", 6'(scount + 1), 6'(SH));

        // R9: range limit latches warning while settled
        half_tick = 0; range_lim = 1;
        cyc("R9");
        chk("R9", {settled, lock_bar}, 2'b11);
        range_lim = 0;
        repeat (5) cyc("R9");
        chk("R9", {settled, lock_bar}, 2'b11);

        // R10/R5: restart by divider write from settled; count again from zero
        n_wr = 1;
        cyc("R10");
        chk("R10", {tuning, settled}, 2'b10);
        n_wr = 0; half_tick = 1;
        repeat (TH - 2) cyc("R10");
        // restart mid tune
        n_wr = 1;
        cyc("R10");
        n_wr = 0;
        repeat (TH - 1) cyc("R10");
        chk("R10", {tuning}, 1'b1);
        cyc("R6");
        chk("R6", {tuning, lock_bar}, 2'b00);
        // range_lim ignored in lock phase
        range_lim = 1;
        cyc("R9");
        chk("R9", {lock_bar}, 1'b0);
        range_lim = 0;

        // R3: pin low forces off regardless of bit
        pwr_pin = 0;
        cyc("R3");
        chk("R3", {ref_en, rf_en, tuning, settled, lock_bar}, 5'b0);
        // R2/R4: pin rise with bit still set restarts
        pwr_pin = 1;
        cyc("R4");
        chk("R4", {ref_en, tuning}, 2'b11);
        // R3: software write of 0
        pd_wr = 1; pd_val = 0;
        cyc("R3");
        chk("R3", {ref_en, rf_en}, 2'b00);
        idle_in();

        // random phase: sparse writes so sequences complete
        for (int i = 0; i < 6000; i++) begin
            half_tick = ($urandom % 3) != 0;
            pwr_pin   = ($urandom % 200) != 0;
            pd_wr     = ($urandom % 150) == 0;
            pd_val    = ($urandom % 4) != 0;
            n_wr      = ($urandom % 120) == 0;
            range_lim = ($urandom % 25) == 0;
            cyc("R2");
        end
        idle_in();
        cyc("R2");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule